// File: doc/BRIEF.md
# Execute Stage: ALU, Flags and Branch Decision

This block is the execute stage of a single-cycle 32-bit processor. Each cycle it takes the decoded opcode, the function code and three operand words. It picks the second ALU operand and the ALU function from the opcode and produces the result word `valE` combinationally. The only state it keeps is a three-bit flag register: zero, sign and signed overflow.

The flag register is written on the rising clock edge only when the instruction is an arithmetic/logic operation. A conditional jump does not change the flags. It compares its function code against the stored flags and drives `takeBranch`. For every other opcode `takeBranch` is held low.

Opcode encoding (4 bits): 0 halt, 1 nop, 2 register move, 3 immediate move, 4 register-to-memory move, 5 memory-to-register move, 6 ALU operation, 7 jump, 8 call, 9 return, 10 push, 11 pop, 12–15 unused.

Top module: `exec_unit`

## Requirements
- R1: For opcodes 2 and 6 the second operand is `valA`. For opcodes 3, 4 and 5 it is `valC`. With the add function, `valE = valB + operand`.
- R2: For call (8) and push (10), `valE = valB - 4`. For return (9) and pop (11), `valE = valB + 4`.
- R3: For opcode 6, `ifun` selects the function: 0 gives `valB + valA`, 1 gives `valB - valA`, 2 gives bitwise AND and 3 gives bitwise XOR. Values 4–15 give add.
- R4: The flag register loads on a rising clock edge only while the opcode is 6. Every other opcode leaves the flags unchanged.
- R5: When the flags load, Z is set when the result is all zeros and S is result bit 31. For add and sub, O is the signed two's-complement overflow of that operation. For AND and XOR, O is cleared.
- R6: An asynchronous active-low reset sets Z=1, S=0 and O=0.
- R7: For opcode 7, `takeBranch` follows `ifun`: 0 always, 1 `(S^O)|Z`, 2 `S^O`, 3 `Z`, 4 `!Z`, 5 `!(S^O)`, 6 `!(S^O)&!Z`. Codes 7–15 are never taken.
- R8: `takeBranch` is 0 whenever the opcode is not 7.
- R9: Opcodes 0, 1, 7 and 12–15 pass `valB` through unchanged to `valE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| icode | input | 4 | Decoded opcode |
| ifun | input | 4 | Function code (ALU function or jump condition) |
| valA | input | 32 | First register operand |
| valB | input | 32 | Second register operand (base of every sum) |
| valC | input | 32 | Constant word from the instruction |
| valE | output | 32 | ALU result |
| takeBranch | output | 1 | Conditional-jump decision |

## Verification
A wrong second-operand select or a wrong function decode shows up on `valE` in the same cycle. The bench checks `valE` combinationally for every opcode class.

A wrong flag value cannot be seen directly at the ports. It shows up only at the next jump: `takeBranch` reports the wrong decision as soon as a jump follows the bad flag load. For that reason each flag-setting case is followed by jumps whose conditions separate Z, S and O. Overflow is set first and then a logic operation runs, so a stale O would flip the less-than decision. Non-ALU instructions are also run between a flag load and the jump, so a spurious load turns a known equal/not-equal answer around.

// File: rtl/exec_pkg.sv
package exec_pkg;
  // opcode values
  localparam logic [3:0] IC_HALT  = 4'd0;
  localparam logic [3:0] IC_NOP   = 4'd1;
  localparam logic [3:0] IC_RRMOV = 4'd2;
  localparam logic [3:0] IC_IRMOV = 4'd3;
  localparam logic [3:0] IC_RMMOV = 4'd4;
  localparam logic [3:0] IC_MRMOV = 4'd5;
  localparam logic [3:0] IC_ALU   = 4'd6;
  localparam logic [3:0] IC_JUMP  = 4'd7;
  localparam logic [3:0] IC_CALL  = 4'd8;
  localparam logic [3:0] IC_RET   = 4'd9;
  localparam logic [3:0] IC_PUSH  = 4'd10;
  localparam logic [3:0] IC_POP   = 4'd11;

  // jump condition codes
  localparam logic [3:0] JC_ALWAYS = 4'd0;
  localparam logic [3:0] JC_LE     = 4'd1;
  localparam logic [3:0] JC_LT     = 4'd2;
  localparam logic [3:0] JC_EQ     = 4'd3;
  localparam logic [3:0] JC_NE     = 4'd4;
  localparam logic [3:0] JC_GE     = 4'd5;
  localparam logic [3:0] JC_GT     = 4'd6;

  typedef enum logic [2:0] {
    OPA_ZERO, OPA_VALA, OPA_VALC, OPA_MINUS, OPA_PLUS
  } opa_sel_e;

  typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_AND, FN_XOR} alu_fn_e;

  typedef struct packed {
    opa_sel_e opSel;
    alu_fn_e  fun;
    logic     setFlags;
    logic     isJump;
  } exec_ctl_t;

  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{z: 1'b1, s: 1'b0, o: 1'b0};
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic [3:0] icode,
  input  logic [3:0] ifun,
  output exec_ctl_t  ctl
);
  always_comb begin
    ctl.opSel    = OPA_ZERO;
    ctl.fun      = FN_ADD;
    ctl.setFlags = 1'b0;
    ctl.isJump   = 1'b0;
    case (icode)
      IC_RRMOV: ctl.opSel = OPA_VALA;
      IC_ALU: begin
        ctl.opSel    = OPA_VALA;
        ctl.setFlags = 1'b1;
        case (ifun)
          4'd1:    ctl.fun = FN_SUB;
          4'd2:    ctl.fun = FN_AND;
          4'd3:    ctl.fun = FN_XOR;
          default: ctl.fun = FN_ADD;
        endcase
      end
      IC_IRMOV, IC_RMMOV, IC_MRMOV: ctl.opSel = OPA_VALC;
      IC_CALL, IC_PUSH:             ctl.opSel = OPA_MINUS;
      IC_RET, IC_POP:               ctl.opSel = OPA_PLUS;
      IC_JUMP:                      ctl.isJump = 1'b1;
      default:                      ctl.opSel = OPA_ZERO;
    endcase
  end
endmodule

// File: rtl/exec_dp.sv
module exec_dp
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  exec_ctl_t         ctl,
  input  logic [3:0]        ifun,
  input  logic [DATA_W-1:0] valA,
  input  logic [DATA_W-1:0] valB,
  input  logic [DATA_W-1:0] valC,
  output logic [DATA_W-1:0] valE,
  output logic              takeBranch
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] STEP_W = DATA_W'(STEP);

  logic [DATA_W-1:0] opA, sumRes, diffRes;
  logic   addOvf, subOvf, sxo;
  flags_t flags, nextFlags;

  always_comb begin
    case (ctl.opSel)
      OPA_VALA:  opA = valA;
      OPA_VALC:  opA = valC;
      OPA_MINUS: opA = -STEP_W;
      OPA_PLUS:  opA = STEP_W;
      default:   opA = '0;
    endcase
  end

  assign sumRes  = valB + opA;
  assign diffRes = valB - opA;
  assign addOvf  = (opA[MSB] == valB[MSB]) && (sumRes[MSB] != valB[MSB]);
  assign subOvf  = (opA[MSB] != valB[MSB]) && (diffRes[MSB] != valB[MSB]);

  always_comb begin
    nextFlags.o = 1'b0;
    case (ctl.fun)
      FN_SUB: begin valE = diffRes;     nextFlags.o = subOvf; end
      FN_AND:       valE = valB & opA;
      FN_XOR:       valE = valB ^ opA;
      default: begin valE = sumRes;     nextFlags.o = addOvf; end
    endcase
    nextFlags.z = (valE == '0);
    nextFlags.s = valE[MSB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flags <= FLAGS_RESET;
    else if (ctl.setFlags) flags <= nextFlags;
  end

  always_comb begin
    sxo = flags.s ^ flags.o;
    case (ifun)
      JC_ALWAYS: takeBranch = ctl.isJump;
      JC_LE:     takeBranch = ctl.isJump & (sxo | flags.z);
      JC_LT:     takeBranch = ctl.isJump & sxo;
      JC_EQ:     takeBranch = ctl.isJump & flags.z;
      JC_NE:     takeBranch = ctl.isJump & ~flags.z;
      JC_GE:     takeBranch = ctl.isJump & ~sxo;
      JC_GT:     takeBranch = ctl.isJump & ~sxo & ~flags.z;
      default:   takeBranch = 1'b0;
    endcase
  end

  // R4: flags unchanged across a non-ALU cycle
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.setFlags |=> $stable(flags));

  // R5: logic ops leave overflow clear
  a_r5_logic_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setFlags && (ctl.fun == FN_AND || ctl.fun == FN_XOR)) |=> !flags.o);

  // R5: zero flag records whether the loaded result was zero
  a_r5_zero_tracks: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setFlags |=> (flags.z == ($past(valE) == '0)));
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        icode,
  input  logic [3:0]        ifun,
  input  logic [DATA_W-1:0] valA,
  input  logic [DATA_W-1:0] valB,
  input  logic [DATA_W-1:0] valC,
  output logic [DATA_W-1:0] valE,
  output logic              takeBranch
);
  exec_ctl_t ctl;

  exec_ctrl u_ctrl (.icode(icode), .ifun(ifun), .ctl(ctl));

  exec_dp #(.DATA_W(DATA_W), .STEP(STEP)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ifun(ifun),
    .valA(valA), .valB(valB), .valC(valC),
    .valE(valE), .takeBranch(takeBranch)
  );

  // R8: no branch outside jumps
  a_r8_branch_only_jump: assert property (@(posedge clk) disable iff (!rstN)
    (icode != IC_JUMP) |-> !takeBranch);

  // R2: stack-down instructions step by STEP
  a_r2_stack_down: assert property (@(posedge clk) disable iff (!rstN)
    (icode == IC_CALL || icode == IC_PUSH) |-> (valE == valB - DATA_W'(STEP)));

  // R3: subtract order is valB minus valA
  a_r3_sub_order: assert property (@(posedge clk) disable iff (!rstN)
    (icode == IC_ALU && ifun == 4'd1) |-> (valE == valB - valA));
endmodule

// File: tb/exec_unit_bench.sv
module exec_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  icode = 4'd1, ifun = 4'd0;
  logic [31:0] valA = '0, valB = '0, valC = '0;
  logic [31:0] valE;
  logic        takeBranch;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exec_unit u_exec_unit (.clk(clk), .rstN(rstN), .icode(icode), .ifun(ifun),
    .valA(valA), .valB(valB), .valC(valC), .valE(valE), .takeBranch(takeBranch));

  // {icode, ifun, valA, valB, valC, expected valE}
  localparam int NV = 16;
  localparam logic [135:0] VECS [NV] = '{
    {4'd2,  4'd0, 32'h5,        32'h10,       32'h99,       32'h15},       // R1
    {4'd3,  4'd0, 32'h0,        32'h7,        32'h100,      32'h107},      // R1
    {4'd4,  4'd0, 32'h77,       32'h1000,     32'h8,        32'h1008},     // R1
    {4'd5,  4'd0, 32'h0,        32'h20,       32'hFFFFFFFC, 32'h1C},       // R1
    {4'd6,  4'd0, 32'h3,        32'h4,        32'h50,       32'h7},        // R3
    {4'd6,  4'd1, 32'h3,        32'hA,        32'h0,        32'h7},        // R3
    {4'd6,  4'd2, 32'hF0F0,     32'hFF00,     32'h0,        32'hF000},     // R3
    {4'd6,  4'd3, 32'hF0F0,     32'hFF00,     32'h0,        32'h0FF0},     // R3
    {4'd8,  4'd0, 32'h9,        32'h200,      32'h5,        32'h1FC},      // R2
    {4'd10, 4'd0, 32'h9,        32'h0,        32'h5,        32'hFFFFFFFC}, // R2
    {4'd9,  4'd0, 32'h9,        32'h1FC,      32'h5,        32'h200},      // R2
    {4'd11, 4'd0, 32'h9,        32'hFFFFFFFC, 32'h5,        32'h0},        // R2
    {4'd1,  4'd0, 32'h5,        32'h9,        32'h7,        32'h9},        // R9
    {4'd7,  4'd0, 32'h5,        32'h33,       32'h7,        32'h33},       // R9
    {4'd13, 4'd0, 32'h5,        32'h44,       32'h7,        32'h44},       // R9
    {4'd6,  4'd5, 32'h1,        32'h2,        32'h0,        32'h3}         // R3
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ic, input logic [3:0] fn,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    icode = ic; ifun = fn; valA = a; valB = b; valC = c;
    #5;
  endtask

  // run one ALU op and clock it into the flags
  task automatic aluOp(input logic [3:0] fn, input logic [31:0] a, input logic [31:0] b);
    drive(4'd6, fn, a, b, 32'h0);
    @(posedge clk);
  endtask

  task automatic jumpChk(input string req, input logic [3:0] fn, input logic exp);
    drive(4'd7, fn, 32'h0, 32'h0, 32'h0);
    check(req, {31'b0, takeBranch}, {31'b0, exp});
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    // R6: reset flags Z=1 S=0 O=0, read through jump decisions
    repeat (2) @(posedge clk);
    jumpChk("R6 eq after reset", 4'd3, 1'b1);
    jumpChk("R6 ne after reset", 4'd4, 1'b0);
    jumpChk("R6 lt after reset", 4'd2, 1'b0);
    jumpChk("R6 gt after reset", 4'd6, 1'b0);
    jumpChk("R6 ge after reset", 4'd5, 1'b1);
    jumpChk("R6 le after reset", 4'd1, 1'b1);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][135:132], VECS[i][131:128], VECS[i][127:96],
            VECS[i][95:64], VECS[i][63:32]);
      check($sformatf("R1/R2/R3/R9 vector %0d valE", i), valE, VECS[i][31:0]);
      if (VECS[i][135:132] != 4'd7)
        check($sformatf("R8 vector %0d no branch", i), {31'b0, takeBranch}, 32'b0);
      @(posedge clk);
    end

    // R5/R7: negative result, no overflow: Z0 S1 O0
    aluOp(4'd1, 32'd5, 32'd3);
    jumpChk("R7 lt negative", 4'd2, 1'b1);
    jumpChk("R7 le negative", 4'd1, 1'b1);
    jumpChk("R7 eq negative", 4'd3, 1'b0);
    jumpChk("R7 ne negative", 4'd4, 1'b1);
    jumpChk("R7 ge negative", 4'd5, 1'b0);
    jumpChk("R7 gt negative", 4'd6, 1'b0);

    // R5: add overflow: S1 O1 -> not less
    aluOp(4'd0, 32'h1, 32'h7FFFFFFF);
    jumpChk("R5 add overflow lt", 4'd2, 1'b0);
    jumpChk("R5 add overflow gt", 4'd6, 1'b1);

    // R5: sub overflow: 0x80000000 - 1 -> S0 O1 -> less
    aluOp(4'd1, 32'h1, 32'h80000000);
    jumpChk("R5 sub overflow lt", 4'd2, 1'b1);
    jumpChk("R5 sub overflow ge", 4'd5, 1'b0);

    // R5: logic op after overflow clears O (S1 O0 -> less)
    aluOp(4'd0, 32'h1, 32'h7FFFFFFF);
    aluOp(4'd3, 32'h80000000, 32'h0);
    jumpChk("R5 xor clears overflow lt", 4'd2, 1'b1);

    // R4: non-ALU ops with zero results do not load flags
    aluOp(4'd0, 32'h1, 32'h1);
    drive(4'd2, 4'd0, 32'h0, 32'h0, 32'h0); @(posedge clk);
    drive(4'd5, 4'd0, 32'h0, 32'h0, 32'h0); @(posedge clk);
    drive(4'd11, 4'd0, 32'h0, 32'hFFFFFFFC, 32'h0); @(posedge clk);
    jumpChk("R4 eq held after non-ALU", 4'd3, 1'b0);
    jumpChk("R4 ne held after non-ALU", 4'd4, 1'b1);

    // R7: Z=1 via xor equal; undefined codes never taken
    aluOp(4'd3, 32'h1234, 32'h1234);
    jumpChk("R5 xor zero eq", 4'd3, 1'b1);
    jumpChk("R7 code 7 not taken", 4'd7, 1'b0);
    jumpChk("R7 code 15 not taken", 4'd15, 1'b0);
    jumpChk("R7 always", 4'd0, 1'b1);

    // R8: ALU op with a taken-looking ifun does not branch
    drive(4'd6, 4'd0, 32'h0, 32'h0, 32'h0);
    check("R8 alu op no branch", {31'b0, takeBranch}, 32'b0);
    @(posedge clk);

    // R6: reset mid-run restores Z=1
    aluOp(4'd0, 32'h1, 32'h1);
    @(negedge clk); rstN = 1'b0;
    jumpChk("R6 eq after mid-run reset", 4'd3, 1'b1);
    @(negedge clk); rstN = 1'b1;

    done = 1;
    finishRun();
  end
endmodule